// File: doc/BRIEF.md
# TMDS Symbol Gearbox and Word Aligner

This block sits behind a 5-bit deserializer on one TMDS lane. The deserializer delivers a 5-bit slice on every tick of a clock that runs at twice the pixel rate. The block pairs consecutive slices into 10-bit words and keeps the last two words as a 20-bit bit history. From that history it selects a 10-bit symbol at a bit offset between 0 and 9. It presents one selected symbol every second clock, together with a one-cycle valid strobe.

The symbol boundary is recovered by search. The block counts symbols in fixed-length windows and looks for any of the four DVI control codewords. A window that ends without a codeword advances the bit offset by one position. A run of windows that each held a codeword raises the lock flag. Each colour lane uses its own instance, and the lanes run independently of one another.

Top module: `tmds_sym_aligner`

## Requirements
- R1: A slice is taken on every clock. The first slice of a pair forms bits [4:0] of the word and the second forms bits [9:5]. Within a slice, bit 0 is the earliest bit in time.
- R2: After reset, `sym_vld_o` pulses high on every second clock and is never high on two adjacent clocks.
- R3: The four control codewords are 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011. Only an exact 10-bit match counts as a control codeword.
- R4: `locked_o` rises at the end of the LOCK_WINS-th consecutive window of WIN_SYMS valid symbols that each contained at least one control codeword.
- R5: A window that ends without a control codeword moves the selection one bit later in the stream and restarts the window count.
- R6: When a slip happens, `locked_o` is cleared in that same update.
- R7: While `rst_n` is low at a clock edge, the block returns to offset 0. `locked_o`, `sym_vld_o` and `sym_o` read 0, and all counters are cleared.
- R8: Once locked, `sym_o` reproduces the transmitted 10-bit symbols on their true boundaries, for any stream lead of 0 to 9 bits.
- R9: The offset runs from 0 to 9 and returns to 0 after 9, so the search keeps cycling while no codeword is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| slice_i | input | 5 | Deserialized slice, bit 0 earliest |
| sym_o | output | 10 | Aligned 10-bit symbol |
| sym_vld_o | output | 1 | One-cycle strobe when `sym_o` is new |
| locked_o | output | 1 | Alignment has held for LOCK_WINS windows |

## Verification
The main stimulus is a lane stream with one control codeword in every eight symbols. The codeword is placed between runs of all-ones or all-zeros symbols, so that no misaligned window can form a codeword. Each of the four codewords is sent with a different lead of zero bits. The time to lock then shows how many single-bit slips were taken, and the symbols seen after lock show whether the slice ordering is correct. A codeword-free stream is used twice: once, after a lock, to show that lock is dropped, and once for more than ten windows before a stream is switched in, which shows the offset wrapping from 9 back to 0.

// File: rtl/tmds_align_pkg.sv
// Package: shared widths, types and control-codeword recognition for the
// TMDS lane aligner. Assumes a 5-bit deserializer slice per fast clock.
package tmds_align_pkg;

    localparam int SLICE_W = 5;
    localparam int SYM_W   = 2 * SLICE_W;
    localparam int HIST_W  = 2 * SYM_W;
    localparam int OFF_W   = $clog2(SYM_W);

    typedef logic [SLICE_W-1:0] slice_t;
    typedef logic [SYM_W-1:0]   sym_t;
    typedef logic [HIST_W-1:0]  hist_t;
    typedef logic [OFF_W-1:0]   off_t;

    localparam off_t OFF_LAST = off_t'(SYM_W - 1);

    // True when the symbol exactly equals one of the four control codewords.
    function automatic logic is_ctrl_word(sym_t s);
        return (s == 10'b1101010100) || (s == 10'b0010101011) ||
               (s == 10'b0101010100) || (s == 10'b1010101011);
    endfunction

endpackage

// File: rtl/tmds_slice_gearbox.sv
// Module: tmds_slice_gearbox
// Pairs consecutive 5-bit slices into 10-bit words and shifts each word
// into a 20-bit history, where bit 0 is the oldest bit.
// Assumes: slice bit 0 is earliest in time, and the first slice of a pair is
// the lower half. The pairing phase starts on the first clock after reset.
module tmds_slice_gearbox
    import tmds_align_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  slice_t slice_i,
    output hist_t  hist_o,
    output logic   hist_vld_o
);

    logic   phase_q;
    slice_t low_q;
    hist_t  hist_q;
    logic   vld_q;

    // Toggle the pair phase, hold the low slice, and push a full word into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            low_q   <= '0;
            hist_q  <= '0;
            vld_q   <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
            vld_q   <= phase_q;
            if (!phase_q) begin
                low_q <= slice_i;
            end else begin
                hist_q <= {slice_i, low_q, hist_q[HIST_W-1:SYM_W]};
            end
        end
    end

    assign hist_o     = hist_q;
    assign hist_vld_o = vld_q;

    // R2: a new history word never appears on two adjacent clocks.
    a_r2_hist_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        hist_vld_o |=> !hist_vld_o);

    // R1: the history shifts only in the cycle right after a word is completed.
    a_r1_hist_moves_on_word: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hist_o) |-> hist_vld_o);

endmodule

// File: rtl/tmds_window_select.sv
// Module: tmds_window_select
// Picks a 10-bit symbol out of the 20-bit history at the given bit offset
// and registers it together with a valid strobe.
// Assumes: the offset is in the range 0..SYM_W-1.
module tmds_window_select
    import tmds_align_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  hist_t hist_i,
    input  logic  hist_vld_i,
    input  off_t  off_i,
    output sym_t  sym_o,
    output logic  sym_vld_o
);

    sym_t cand [SYM_W];
    sym_t sym_q;
    logic vld_q;

    // One candidate symbol for each possible bit offset.
    for (genvar k = 0; k < SYM_W; k++) begin : g_cand
        assign cand[k] = hist_i[k +: SYM_W];
    end

    // Capture the candidate at the current offset whenever the history has a new word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= hist_vld_i;
            if (hist_vld_i) begin
                sym_q <= cand[off_i];
            end
        end
    end

    assign sym_o     = sym_q;
    assign sym_vld_o = vld_q;

    // R9: the offset presented to the mux stays within 0..9.
    a_r9_off_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        off_i <= OFF_LAST);

    // R2: the symbol valid strobe is spaced by at least one idle clock.
    a_r2_sym_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld_o |=> !sym_vld_o);

endmodule

// File: rtl/tmds_lock_search.sv
// Module: tmds_lock_search
// Counts symbols in windows of WIN_SYMS and records whether a control
// codeword was seen. A window without one advances the bit offset by one,
// wrapping from 9 to 0. LOCK_WINS windows in a row that each held one raise the lock flag.
// Assumes: sym_vld_i is a single-cycle strobe for each symbol.
module tmds_lock_search
    import tmds_align_pkg::*;
#(
    parameter int WIN_SYMS  = 1 << 20,
    parameter int LOCK_WINS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  sym_t sym_i,
    input  logic sym_vld_i,
    output off_t off_o,
    output logic locked_o
);

    localparam int CNT_W = (WIN_SYMS > 2) ? $clog2(WIN_SYMS) : 1;
    localparam int LCK_W = $clog2(LOCK_WINS + 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_SYMS - 1);
    localparam logic [LCK_W-1:0] LOCK_FULL = LCK_W'(LOCK_WINS);
    localparam logic [LCK_W-1:0] LOCK_PRE  = LCK_W'(LOCK_WINS - 1);

    logic [CNT_W-1:0] win_cnt_q;
    logic [LCK_W-1:0] good_cnt_q;
    logic             hit_q;
    logic             locked_q;
    off_t             off_q;
    logic             sym_hit;
    logic             win_end;
    logic             win_good;

    // Decode the control-codeword hit and the last symbol of the window.
    always_comb begin
        sym_hit  = sym_vld_i && is_ctrl_word(sym_i);
        win_end  = sym_vld_i && (win_cnt_q == WIN_LAST);
        win_good = hit_q || sym_hit;
    end

    // Window bookkeeping: count symbols, then at the window end either slip or credit lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt_q  <= '0;
            good_cnt_q <= '0;
            hit_q      <= 1'b0;
            locked_q   <= 1'b0;
            off_q      <= '0;
        end else if (win_end) begin
            win_cnt_q <= '0;
            hit_q     <= 1'b0;
            if (win_good) begin
                if (good_cnt_q != LOCK_FULL) begin
                    good_cnt_q <= good_cnt_q + 1'b1;
                end
                if (good_cnt_q >= LOCK_PRE) begin
                    locked_q <= 1'b1;
                end
            end else begin
                off_q      <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;
                good_cnt_q <= '0;
                locked_q   <= 1'b0;
            end
        end else if (sym_vld_i) begin
            win_cnt_q <= win_cnt_q + 1'b1;
            hit_q     <= win_good;
        end
    end

    assign off_o    = off_q;
    assign locked_o = locked_q;

    // R5 and R9: the offset only ever steps by one bit and wraps after 9.
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(off_q) |-> (off_q == (($past(off_q) == OFF_LAST) ? '0 : $past(off_q) + 1'b1)));

    // R6: a slip leaves the lane unlocked.
    a_r6_slip_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(off_q) |-> !locked_o);

    // R4: lock can only rise at the end of a window.
    a_r4_lock_on_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(win_end));

    // R4: the credit counter never passes its limit.
    a_r4_credit_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        good_cnt_q <= LOCK_FULL);

endmodule

// File: rtl/tmds_sym_aligner.sv
// Module: tmds_sym_aligner (top)
// One TMDS lane: a 5-bit slice gearbox, a bit-offset symbol selector and a
// codeword-driven slip/lock search. Use one instance per colour lane.
// Assumes: clk runs at twice the pixel rate, and rst_n is synchronous and active low.
module tmds_sym_aligner
    import tmds_align_pkg::*;
#(
    parameter int WIN_SYMS  = 1 << 20,
    parameter int LOCK_WINS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] slice_i,
    output logic [9:0] sym_o,
    output logic       sym_vld_o,
    output logic       locked_o
);

    hist_t hist;
    logic  hist_vld;
    off_t  off;
    sym_t  sym;
    logic  sym_vld;

    tmds_slice_gearbox u_gear (
        .clk       (clk),
        .rst_n     (rst_n),
        .slice_i   (slice_i),
        .hist_o    (hist),
        .hist_vld_o(hist_vld)
    );

    tmds_window_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .hist_i    (hist),
        .hist_vld_i(hist_vld),
        .off_i     (off),
        .sym_o     (sym),
        .sym_vld_o (sym_vld)
    );

    tmds_lock_search #(
        .WIN_SYMS (WIN_SYMS),
        .LOCK_WINS(LOCK_WINS)
    ) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_i    (sym),
        .sym_vld_i(sym_vld),
        .off_o    (off),
        .locked_o (locked_o)
    );

    assign sym_o     = sym;
    assign sym_vld_o = sym_vld;

    // R7: one clock after reset is sampled, the outputs are quiet.
    a_r7_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!locked_o && !sym_vld_o && sym_o == '0));

endmodule

// File: tb/tmds_sym_aligner_tb.sv
// Bench for tmds_sym_aligner: a table of codeword/lead cases walked by one
// loop, followed by directed tests of reset, loss of lock and offset wrap.
module tmds_sym_aligner_tb;

    localparam int WIN  = 16;
    localparam int LCKW = 4;
    localparam logic [9:0] DATA_SYM = 10'b0000011111;
    localparam logic [9:0] CW0 = 10'b1101010100;
    localparam logic [9:0] CW1 = 10'b0010101011;
    localparam logic [9:0] CW2 = 10'b0101010100;
    localparam logic [9:0] CW3 = 10'b1010101011;
    localparam int NCASE = 6;
    // Each entry: codeword[13:4], stream lead in bits[3:0].
    localparam logic [13:0] CASES [NCASE] = '{
        {CW0, 4'd0}, {CW1, 4'd3}, {CW2, 4'd7},
        {CW3, 4'd9}, {CW0, 4'd5}, {CW1, 4'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] slice_i = '0;
    logic [9:0] sym_o;
    logic       sym_vld_o;
    logic       locked_o;

    logic       rst_req = 1'b1;
    logic       force_data = 1'b0;
    logic [9:0] code_v = CW0;
    int         lead = 0;
    int         sw_bit = 0;
    int         gbit = 0;
    int         cyc = 0;
    int         total = 0;
    int         failed = 0;
    int         wd = 0;

    tmds_sym_aligner #(.WIN_SYMS(WIN), .LOCK_WINS(LCKW)) u_dut (
        .clk(clk), .rst_n(rst_n), .slice_i(slice_i),
        .sym_o(sym_o), .sym_vld_o(sym_vld_o), .locked_o(locked_o)
    );

    always #2.5 clk = ~clk;

    // Stream symbol: a codeword every 8th slot, all-bit9 pads after it, all-bit0 pads before it.
    function automatic logic [9:0] stream_sym(logic [9:0] c, int idx);
        int slot = idx % 8;
        if (slot == 0) return c;
        if (slot <= 3) return {10{c[9]}};
        return {10{c[0]}};
    endfunction

    function automatic logic bit_at(int n);
        logic [9:0] s;
        if (force_data || n < sw_bit) return DATA_SYM[n % 10];
        if (n < lead) return 1'b0;
        s = stream_sym(code_v, (n - lead) / 10);
        return s[(n - lead) % 10];
    endfunction

    // Drive the reset and the lane slices on the clock, earliest bit in slice bit 0.
    always @(posedge clk) begin
        rst_n <= !rst_req;
        if (rst_req) begin
            gbit = 0;
            slice_i <= '0;
        end else begin
            slice_i <= {bit_at(gbit + 4), bit_at(gbit + 3), bit_at(gbit + 2),
                        bit_at(gbit + 1), bit_at(gbit)};
            gbit = gbit + 5;
        end
    end

    // Edge counter since reset release: after edge e_n it reads n+1.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else cyc <= cyc + 1;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            total = total + 1;
            failed = failed + 1;
            $display("FAIL watchdog: actual expired expected finish");
            summary();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            failed = failed + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_edge(int n);
        while (cyc != n + 1) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 reset locked", locked_o, 0);
        check("R7 reset valid", sym_vld_o, 0);
        check("R7 reset symbol", sym_o, 0);
        rst_req = 1'b0;
    endtask

    // After lock, every symbol must be one of the stream's symbols, with codewords present.
    task automatic check_symbols(string req, logic [9:0] c);
        int bad = 0;
        int seen = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (sym_vld_o) begin
                if (sym_o == c) seen++;
                else if (sym_o != {10{c[9]}} && sym_o != {10{c[0]}}) bad++;
            end
        end
        check({req, " misaligned symbols"}, bad, 0);
        check({req, " codewords seen"}, (seen >= 3), 1);
    endtask

    initial begin
        // Table walk: R1, R3, R4, R5, R8 for every codeword and several leads.
        for (int t = 0; t < NCASE; t++) begin
            code_v = CASES[t][13:4];
            lead = int'(CASES[t][3:0]);
            sw_bit = 0;
            force_data = 1'b0;
            do_reset();
            // R5: each lead bit costs one window; lock follows LOCK_WINS good windows (R4).
            wait_edge(32 * (lead + LCKW) - 10);
            check("R4 R5 not yet locked", locked_o, 0);
            wait_edge(32 * (lead + LCKW) + 10);
            check("R4 R3 locked", locked_o, 1);
            check_symbols("R8 R1", code_v);
        end

        // R2: the valid strobe alternates, 20 pulses in 40 clocks.
        begin
            int cnt = 0;
            int adj = 0;
            logic prev = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (sym_vld_o) cnt++;
                if (sym_vld_o && prev) adj++;
                prev = sym_vld_o;
            end
            check("R2 pulse count", cnt, 20);
            check("R2 adjacent pulses", adj, 0);
        end

        // R6: a codeword-free stream drops the lock within two windows.
        check("R6 locked before loss", locked_o, 1);
        @(negedge clk);
        force_data = 1'b1;
        repeat (80) @(negedge clk);
        check("R6 lock dropped after slip", locked_o, 0);

        // R7: reset mid-stream clears the outputs (checked inside do_reset).
        force_data = 1'b0;
        code_v = CW0;
        lead = 0;
        sw_bit = 0;
        do_reset();
        wait_edge(200);
        check("R7 relock after reset", locked_o, 1);

        // R9: eleven empty windows wrap the offset 9->0->1; the lead-2 stream then locks after one more slip.
        code_v = CW2;
        lead = 2;
        sw_bit = 1800;
        do_reset();
        wait_edge(350);
        check("R9 no lock on data", locked_o, 0);
        wait_edge(500);
        check("R9 not locked before wrap path done", locked_o, 0);
        wait_edge(525);
        check("R9 locked after wrap", locked_o, 1);
        check_symbols("R9 R8", code_v);

        summary();
    end

endmodule